// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Power-Up Initializer

This block keeps an asynchronous DRAM bank refreshed and runs the start-up sequence the bank needs before normal use. After reset it stays quiet for a programmable pause. It then runs a fixed burst of refresh cycles and raises a ready flag. From then on, an interval timer creates refresh obligations at a steady rate. The obligations are held in a saturating pending counter and worked off one refresh at a time. When the sequencer has been slow, they are worked off back to back.

The block shares the DRAM pins with an access sequencer through a request and grant pair. When it has work, it raises a request and waits for a grant, which means the sequencer has closed its open row. It then owns the bus and drives one refresh waveform. It releases the bus and keeps the request up for one more clock before dropping it.

A static mode input picks the refresh style. In one style the CAS strobe falls before RAS, so the device uses its own row counter. In the other, RAS falls alone over a row address taken from the block's own row counter. An urgency flag rises when the pending count reaches a threshold, so the sequencer can stop holding the grant back.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: During reset and for INIT_PAUSE clocks after it, ras_n and cas_n are high, dram_addr is zero, and rfr_req, rfr_drive, rfr_ready and rfr_urgent are low.
- R2: After the pause the block performs exactly INIT_BURST refresh cycles. rfr_ready rises on the clock that ends the last of them and then stays high until reset.
- R3: With use_ras_only low, each refresh drives cas_n low for T_LEAD clocks before ras_n falls. cas_n stays low for the first T_CASH clocks of the RAS-low time and is high for the rest. we_n is high throughout.
- R4: With use_ras_only high, cas_n stays high during refresh. While the bus is owned, dram_addr carries the row counter, zero-extended. The row counter starts at 0 after reset and advances by one, modulo 2^ROW_BITS, after every refresh.
- R5: ras_n stays low for exactly T_RAS clocks per refresh. It is high for at least T_RP clocks before every fall.
- R6: rfr_drive rises only on the clock after rfr_gnt was sampled high while rfr_req was high. While rfr_drive is low, ras_n and cas_n are high.
- R7: rfr_req stays high for the one clock after rfr_drive falls. It is low on the clock after that.
- R8: Once ready, the pending count rises by one every INTERVAL clocks and falls by one when a refresh completes. Both in the same clock leave it unchanged. It saturates at 2^PEND_W-1, and refreshes done in the initial burst do not lower it.
- R9: rfr_urgent is high exactly when the pending count is at least URGENT_LEVEL.
- R10: From idle, a nonzero pending count or unfinished burst raises rfr_req on the next clock. After a refresh ends, the next request follows after a single low clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_ras_only | input | 1 | 1 selects row-addressed refresh, 0 selects CAS-first refresh; change only in reset |
| rfr_gnt | input | 1 | Grant from the access sequencer; its row is closed |
| rfr_req | output | 1 | Refresh request to the access sequencer |
| rfr_urgent | output | 1 | Pending count reached URGENT_LEVEL |
| rfr_drive | output | 1 | Block currently owns the DRAM control and address pins |
| rfr_ready | output | 1 | Initialisation burst complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| dram_addr | output | ADDR_W | Row address during row-addressed refresh, zero otherwise |

## Verification
The bench uses a 30-clock pause, a 60-clock refresh interval, a 3-bit row counter on a 5-bit address bus and a 3-bit pending counter with an urgency level of 3. The default timing counts are kept. The short interval lets the grant be withheld long enough to reach pending saturation at 7 and then watch the back-to-back catch-up. The 3-bit row counter wraps right at the end of the eight-cycle initial burst, so the wrap to row 0 falls on the first interval refresh. Both refresh styles are run from separate resets, and the grant delay rotates between zero and three clocks.

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int ADDR_W       = 13,
  parameter int ROW_BITS     = 12,
  parameter int INIT_PAUSE   = 25000,
  parameter int INIT_BURST   = 8,
  parameter int INTERVAL     = 1950,
  parameter int PEND_W       = 4,
  parameter int URGENT_LEVEL = 4,
  parameter int T_LEAD       = 1,
  parameter int T_CASH       = 2,
  parameter int T_RAS        = 8,
  parameter int T_RP         = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_ras_only,
  input  logic              rfr_gnt,
  output logic              rfr_req,
  output logic              rfr_urgent,
  output logic              rfr_drive,
  output logic              rfr_ready,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] dram_addr
);
  localparam int TMR_W = $clog2(INIT_PAUSE + T_RAS + T_RP + T_LEAD + 1);
  localparam int IV_W  = $clog2(INTERVAL + 1);
  localparam int BU_W  = $clog2(INIT_BURST + 1);
  localparam logic [TMR_W-1:0] PAUSE_LD = TMR_W'(INIT_PAUSE - 1);
  localparam logic [TMR_W-1:0] LEAD_LD  = TMR_W'(T_LEAD - 1);
  localparam logic [TMR_W-1:0] RAS_LD   = TMR_W'(T_RAS - 1);
  localparam logic [TMR_W-1:0] RP_LD    = TMR_W'(T_RP - 1);
  localparam logic [TMR_W-1:0] CASH_LIM = TMR_W'(T_RAS - 1 - T_CASH);
  localparam logic [IV_W-1:0]  IV_LD    = IV_W'(INTERVAL - 1);
  localparam logic [BU_W-1:0]  BU_LD    = BU_W'(INIT_BURST);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  localparam logic [PEND_W-1:0] URG_LVL  = PEND_W'(URGENT_LEVEL);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_REQ, S_LEAD, S_RASLO, S_PRE, S_DONE} st_t;

  st_t               st;
  logic [TMR_W-1:0]  tmr;
  logic [IV_W-1:0]   ivc;
  logic [BU_W-1:0]   burst;
  logic [PEND_W-1:0] pend;
  logic [ROW_BITS-1:0] row;

  wire last  = (tmr == '0);
  wire fin   = (st == S_PRE) && last;
  wire tick  = rfr_ready && (ivc == '0);
  wire dec   = fin && (burst == '0);
  wire work  = (burst != '0) || (pend != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_PAUSE;
      tmr   <= PAUSE_LD;
      burst <= BU_LD;
      row   <= '0;
    end else begin
      case (st)
        S_PAUSE: if (last) st <= S_IDLE; else tmr <= tmr - 1'b1;
        S_IDLE:  if (work) st <= S_REQ;
        S_REQ:   if (rfr_gnt) begin st <= S_LEAD; tmr <= LEAD_LD; end
        S_LEAD:  if (last) begin st <= S_RASLO; tmr <= RAS_LD; end else tmr <= tmr - 1'b1;
        S_RASLO: if (last) begin st <= S_PRE; tmr <= RP_LD; end else tmr <= tmr - 1'b1;
        S_PRE: begin
          if (last) begin
            st <= S_DONE;
            if (use_ras_only) row <= row + 1'b1;
            if (burst != '0) burst <= burst - 1'b1;
          end else tmr <= tmr - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivc  <= IV_LD;
      pend <= '0;
    end else begin
      if (rfr_ready) ivc <= (ivc == '0) ? IV_LD : ivc - 1'b1;
      if (tick && !dec && pend != PEND_MAX) pend <= pend + 1'b1;
      else if (dec && !tick) pend <= pend - 1'b1;
    end
  end

  wire cas_win = (st == S_LEAD) || ((st == S_RASLO) && (tmr > CASH_LIM));

  assign rfr_ready  = (burst == '0) && (st != S_PAUSE);
  assign rfr_urgent = (pend >= URG_LVL);
  assign rfr_drive  = (st == S_LEAD) || (st == S_RASLO) || (st == S_PRE);
  assign rfr_req    = rfr_drive || (st == S_REQ) || (st == S_DONE);
  assign ras_n      = (st != S_RASLO);
  assign cas_n      = !(cas_win && !use_ras_only);
  assign we_n       = 1'b1;
  assign dram_addr  = (rfr_drive && use_ras_only) ? ADDR_W'(row) : '0;
endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
  parameter int T_CASH = 2,
  parameter int T_RAS  = 8,
  parameter int T_RP   = 5
) (
  input logic clk,
  input logic rst_n,
  input logic use_ras_only,
  input logic rfr_gnt,
  input logic rfr_req,
  input logic rfr_drive,
  input logic rfr_ready,
  input logic rfr_urgent,
  input logic ras_n,
  input logic cas_n
);
  logic [7:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= 8'hff;
      lo_cnt <= '0;
    end else if (ras_n) begin
      hi_cnt <= (hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 1'b1;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= '0;
      lo_cnt <= (lo_cnt == 8'hff) ? lo_cnt : lo_cnt + 1'b1;
    end
  end

  // R2
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) rfr_ready |=> rfr_ready);
  // R3
  cbr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_ras_only && $fell(ras_n)) |-> (!cas_n && $past(!cas_n)));
  // R3
  cbr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((T_CASH > 1) && !use_ras_only && $fell(ras_n)) |=> !cas_n);
  // R4
  rasonly_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ras_only && !ras_n) |-> cas_n);
  // R5
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 8'(T_RP)));
  // R5
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt == 8'(T_RAS)));
  // R6
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rfr_drive |-> (ras_n && cas_n));
  // R6
  grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfr_drive) |-> $past(rfr_gnt && rfr_req));
  // R7
  req_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfr_drive) |-> rfr_req);
  // R7
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfr_drive) |=> !rfr_req);
  // R9
  urgent_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfr_urgent |-> rfr_ready);
endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(.T_CASH(T_CASH), .T_RAS(T_RAS), .T_RP(T_RP)) chk (.*);

// File: tb/dram_refresh_ctrl_test.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_test;
  localparam int AW = 5, RB = 3, PAUSE = 30, BURST = 8, IVL = 60, PW = 3, URG = 3;
  localparam int TL = 1, TC = 2, TR = 8, TP = 5;
  localparam int PMAX = (1 << PW) - 1;

  logic clk = 0, rst_n = 0, mode = 0, rfr_gnt = 0;
  logic rfr_req, rfr_urgent, rfr_drive, rfr_ready, ras_n, cas_n, we_n;
  logic [AW-1:0] dram_addr;

  dram_refresh_ctrl #(.ADDR_W(AW), .ROW_BITS(RB), .INIT_PAUSE(PAUSE), .INIT_BURST(BURST),
    .INTERVAL(IVL), .PEND_W(PW), .URGENT_LEVEL(URG), .T_LEAD(TL), .T_CASH(TC), .T_RAS(TR),
    .T_RP(TP)) uut (.clk(clk), .rst_n(rst_n), .use_ras_only(mode), .rfr_gnt(rfr_gnt),
    .rfr_req(rfr_req), .rfr_urgent(rfr_urgent), .rfr_drive(rfr_drive), .rfr_ready(rfr_ready),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dram_addr(dram_addr));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // grant driver
  bit hold = 0;
  int wcnt = 0, gdly = 0;
  always @(negedge clk) begin
    if (!rst_n || !rfr_req) begin
      rfr_gnt <= 0; wcnt <= 0;
    end else if (!hold && !rfr_gnt) begin
      if (wcnt >= gdly) begin rfr_gnt <= 1; gdly <= (gdly + 1) % 4; end
      else wcnt <= wcnt + 1;
    end
  end

  // reference model
  int cyc, rcyc, pend, burst, row;
  bit rdy, gnt_s;
  bit e_ras, e_cas, e_req, e_drv;
  int e_addr;

  task automatic adv(input bit fin);
    int t;
    @(posedge clk);
    gnt_s = rfr_gnt;
    cyc++;
    t = (rdy && ((cyc - rcyc) % IVL == 0)) ? 1 : 0;
    pend = pend + t - (fin ? 1 : 0);
    if (pend > PMAX) pend = PMAX;
  endtask

  task automatic model_run(input int lim);
    cyc = 0; rcyc = 0; pend = 0; burst = BURST; row = 0; rdy = 0;
    e_ras = 1; e_cas = 1; e_req = 0; e_drv = 0; e_addr = 0;
    repeat (PAUSE) adv(0);
    while (cyc < lim) begin
      if (burst > 0 || pend > 0) begin
        adv(0); e_req = 1;
        do adv(0); while (!gnt_s);
        e_drv = 1; e_addr = mode ? row : 0; e_cas = mode;
        repeat (TL - 1) adv(0);
        for (int i = 0; i < TR; i++) begin
          adv(0); e_ras = 0; e_cas = mode || (i >= TC);
        end
        for (int i = 0; i < TP; i++) begin
          adv(0); e_ras = 1; e_cas = 1;
        end
        adv(burst == 0);
        if (burst > 0) begin
          burst--;
          if (burst == 0) begin rdy = 1; rcyc = cyc; end
        end
        if (mode) row = (row + 1) % (1 << RB);
        e_drv = 0; e_addr = 0;
        adv(0); e_req = 0;
      end else adv(0);
    end
  endtask

  bit cmp_en = 0;
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R5 ras_n", ras_n, e_ras);
      chk(mode ? "R4 cas_n" : "R3 cas_n", cas_n, e_cas);
      chk("R3 we_n", we_n, 1);
      chk("R4 dram_addr", dram_addr, e_addr);
      chk("R7 R10 rfr_req", rfr_req, e_req);
      chk("R6 rfr_drive", rfr_drive, e_drv);
      chk("R2 rfr_ready", rfr_ready, rdy);
      chk("R8 R9 rfr_urgent", rfr_urgent, (pend >= URG) ? 1 : 0);
    end
  end

  // side monitors
  bit prev_ras = 1, prev_rdy = 0, urg_seen = 0;
  int falls_pre = 0, nrow = 0;
  int rows[16];
  always @(negedge clk) begin
    if (!rst_n) begin
      falls_pre = 0; nrow = 0; prev_ras = 1; prev_rdy = 0;
    end else begin
      if (prev_ras && !ras_n) begin
        if (!rfr_ready) falls_pre++;
        if (nrow < 16) begin rows[nrow] = dram_addr; nrow++; end
      end
      if (rfr_ready && !prev_rdy) chk("R2 burst length", falls_pre, BURST);
      if (rfr_urgent) urg_seen = 1;
      prev_ras = ras_n; prev_rdy = rfr_ready;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", wd, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic reset_checks();
    chk("R1 ras_n", ras_n, 1);
    chk("R1 cas_n", cas_n, 1);
    chk("R1 rfr_req", rfr_req, 0);
    chk("R1 rfr_drive", rfr_drive, 0);
    chk("R1 rfr_ready", rfr_ready, 0);
    chk("R1 rfr_urgent", rfr_urgent, 0);
    chk("R1 dram_addr", dram_addr, 0);
  endtask

  initial begin
    rst_n = 0; mode = 0;
    repeat (3) @(negedge clk);
    reset_checks();
    rst_n = 1; cmp_en = 1;
    fork
      model_run(1300);
      begin
        repeat (250) @(negedge clk); hold = 1;
        repeat (500) @(negedge clk); hold = 0;
      end
    join
    cmp_en = 0;
    chk("R9 urgent seen during withheld grant", urg_seen, 1);
    @(negedge clk);
    rst_n = 0; mode = 1;
    repeat (3) @(negedge clk);
    reset_checks();
    rst_n = 1; cmp_en = 1;
    model_run(700);
    cmp_en = 0;
    chk("R4 refresh count", (nrow >= 12) ? 1 : 0, 1);
    for (int i = 0; i < 12; i++) chk("R4 row order", rows[i], i % (1 << RB));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule